// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block is the register-side interrupt controller of a PC-style serial port. It holds four pending interrupt causes: line error, received byte, transmitter ready and modem change. It masks them with a four-bit enable register and picks the most urgent one for the identification register. It drives a level interrupt request through a gate bit in the modem control register. Host reads of the identification, line status, modem status and data registers retire the causes they report.

The host reaches eight byte registers through a 3-bit offset with separate read and write strobes. Read data is combinational from the current state, and every read side effect takes place at the clock edge that ends the read cycle. The serial datapath reports events through single-cycle strobes: received byte, transmitter ready, a 4-bit line error vector and a 4-bit modem delta vector. Baud generation and shifting live elsewhere, and the received byte is only passed through to the data register read.

Top module: `uart_irq_ident`

## Requirements
- R1: A read at offset 2 returns identification code 0x01 when no enabled cause is pending. Otherwise it returns 0x06 for line error, 0x04 for received byte, 0x02 for transmitter ready and 0x00 for modem change.
- R2: When several enabled causes are pending, the code reports the highest one in the order line error, received byte, transmitter ready, modem change.
- R3: The enable register at offset 1 (divisor latch bit clear) maps bit 0 to received byte, bit 1 to transmitter ready, bit 2 to line error and bit 3 to modem change. Only bits 3:0 of a write are kept, and bits 7:4 read as zero.
- R4: `irq` is high only when some enabled cause is pending and modem control (offset 4) bit 3 is set. It is a register that follows such a change one clock later.
- R5: A read at offset 2 that returns code 0x02 retires the transmitter-ready cause. A read that returns any other code leaves that cause pending.
- R6: Writing offset 2 with bit 0 set turns FIFO mode on, and identification reads then have bits 7:6 set. Writing bit 0 clear turns FIFO mode off.
- R7: Reading line status (offset 5) clears its bits 4:1 and retires the line error cause. Bits 0 and 5 are kept.
- R8: Reading modem status (offset 6) clears its bits 3:0 and retires the modem change cause. Bits 7:4 are kept.
- R9: A host write to line status stores the byte. It raises received byte if bit 0 is set, line error if any of bits 4:1 is set, and transmitter ready if bit 5 is set. A host write to modem status stores the byte and raises modem change if any of bits 3:0 is set.
- R10: With line control (offset 3) bit 7 set, offsets 0 and 1 read and write the low and high divisor bytes, and the enable register is left untouched.
- R11: `evt_rx` sets line status bit 0 and raises received byte, and `evt_tx` sets bit 5 and raises transmitter ready. A nonzero `line_err` is ORed into line status bits 4:1 and raises line error. A nonzero `modem_delta` is ORed into modem status bits 3:0 and raises modem change. An event in the same cycle as a read that would retire its cause wins, and the cause stays pending.
- R12: A read at offset 0 with the divisor latch bit clear returns `rx_data`, clears line status bit 0 and retires the received byte cause.
- R13: After reset, all causes are cleared and `irq` is low. The enable, line control, modem control, line status, modem status, FIFO mode, scratch and divisor registers are zero, so offset 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe; side effects at the clock edge |
| bus_rdata | output | 8 | Read data for the current offset |
| evt_rx | input | 1 | Datapath: a byte was received |
| evt_tx | input | 1 | Datapath: the transmitter can take a byte |
| line_err | input | 4 | Datapath: line error flags for status bits 4:1 |
| modem_delta | input | 4 | Datapath: modem change flags for status bits 3:0 |
| rx_data | input | 8 | Received byte returned at offset 0 |
| irq | output | 1 | Registered interrupt request |

## Verification
A clearing host read and a datapath event for the same cause can land in the same clock. Examples are a line status read while a new line error arrives, or an identification read that returns 0x02 while the transmitter reports ready again. The bench drives the read strobe and the event strobe together for one cycle. It checks that the read returns the old value, and that the next reads show the cause still pending with the new status bits present.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int N_SRC = 4;
    localparam int ERR_W = 4;

    // cause index equals its enable bit position
    localparam int SRC_RX    = 0;
    localparam int SRC_TX    = 1;
    localparam int SRC_LINE  = 2;
    localparam int SRC_MODEM = 3;

    // urgency order, most urgent first
    localparam int PRIO [N_SRC] = '{SRC_LINE, SRC_RX, SRC_TX, SRC_MODEM};

    typedef logic [N_SRC-1:0] src_vec_t;
    typedef logic [DW-1:0]    byte_t;

    typedef enum logic [AW-1:0] {
        OFS_DATA = 3'd0,
        OFS_IER  = 3'd1,
        OFS_IID  = 3'd2,
        OFS_LCR  = 3'd3,
        OFS_MCR  = 3'd4,
        OFS_LSR  = 3'd5,
        OFS_MSR  = 3'd6,
        OFS_SCR  = 3'd7
    } ofs_e;

    typedef struct packed {
        logic       any;
        logic [1:0] id;
    } ident_t;

    function automatic logic [1:0] src_id(input int s);
        case (s)
            SRC_LINE: return 2'd3;
            SRC_RX:   return 2'd2;
            SRC_TX:   return 2'd1;
            default:  return 2'd0;
        endcase
    endfunction

    function automatic byte_t ident_byte(input ident_t w, input logic fifo);
        return {{2{fifo}}, 3'b000, w.id, ~w.any};
    endfunction

endpackage

// File: rtl/uirq_pending.sv
module uirq_pending
    import uirq_pkg::*;
#(
    parameter int N = N_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);

    for (genvar g = 0; g < N; g++) begin : g_src
        logic q;
        always_ff @(posedge clk) begin
            if (rst)         q <= 1'b0;
            else if (set[g]) q <= 1'b1;
            else if (clr[g]) q <= 1'b0;
        end
        assign pend[g] = q;

        // R11: a raise in the same cycle as a retire keeps the cause
        p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
            set[g] |=> pend[g]);
    end

endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  src_vec_t pend,
    input  src_vec_t ena,
    output ident_t   ident
);

    src_vec_t active;

    always_comb begin
        active    = pend & ena;
        ident.any = 1'b0;
        ident.id  = 2'd0;
        for (int k = N_SRC - 1; k >= 0; k--) begin
            if (active[PRIO[k]]) begin
                ident.any = 1'b1;
                ident.id  = src_id(PRIO[k]);
            end
        end
    end

endmodule

// File: rtl/uirq_gate.sv
module uirq_gate (
    input  logic clk,
    input  logic rst,
    input  logic any,
    input  logic out2,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any & out2;
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_wr,
    input  logic             bus_rd,
    output logic [DW-1:0]    bus_rdata,
    input  logic             evt_rx,
    input  logic             evt_tx,
    input  logic [ERR_W-1:0] line_err,
    input  logic [ERR_W-1:0] modem_delta,
    input  logic [DW-1:0]    rx_data,
    output logic             irq
);

    src_vec_t ier_q;
    byte_t    lcr_q, mcr_q, lsr_q, msr_q, scr_q, dll_q, dlm_q;
    logic     fifo_q;
    byte_t    lsr_d, msr_d;
    src_vec_t pend, set_v, clr_v;
    ident_t   ident;
    logic     dlab;
    ofs_e     ofs;

    assign dlab = lcr_q[7];
    assign ofs  = ofs_e'(bus_addr);

    // host access decode
    logic wr_ier, wr_dll, wr_dlm, wr_fcr, wr_lcr, wr_mcr, wr_lsr, wr_msr, wr_scr;
    logic rd_data, rd_iid, rd_lsr, rd_msr;

    always_comb begin
        wr_ier  = bus_wr && ofs == OFS_IER  && !dlab;
        wr_dll  = bus_wr && ofs == OFS_DATA &&  dlab;
        wr_dlm  = bus_wr && ofs == OFS_IER  &&  dlab;
        wr_fcr  = bus_wr && ofs == OFS_IID;
        wr_lcr  = bus_wr && ofs == OFS_LCR;
        wr_mcr  = bus_wr && ofs == OFS_MCR;
        wr_lsr  = bus_wr && ofs == OFS_LSR;
        wr_msr  = bus_wr && ofs == OFS_MSR;
        wr_scr  = bus_wr && ofs == OFS_SCR;
        rd_data = bus_rd && ofs == OFS_DATA && !dlab;
        rd_iid  = bus_rd && ofs == OFS_IID;
        rd_lsr  = bus_rd && ofs == OFS_LSR;
        rd_msr  = bus_rd && ofs == OFS_MSR;
    end

    // cause raise and retire vectors
    always_comb begin
        set_v            = '0;
        set_v[SRC_RX]    = evt_rx | (wr_lsr & bus_wdata[0]);
        set_v[SRC_TX]    = evt_tx | (wr_lsr & bus_wdata[5]);
        set_v[SRC_LINE]  = (|line_err) | (wr_lsr & (|bus_wdata[4:1]));
        set_v[SRC_MODEM] = (|modem_delta) | (wr_msr & (|bus_wdata[3:0]));

        clr_v            = '0;
        clr_v[SRC_RX]    = rd_data;
        clr_v[SRC_TX]    = rd_iid && ident.any && ident.id == src_id(SRC_TX);
        clr_v[SRC_LINE]  = rd_lsr;
        clr_v[SRC_MODEM] = rd_msr;
    end

    // status register next values
    always_comb begin
        lsr_d = lsr_q;
        if (rd_lsr)  lsr_d[4:1] = '0;
        if (rd_data) lsr_d[0]   = 1'b0;
        if (wr_lsr)  lsr_d      = bus_wdata;
        if (evt_rx)  lsr_d[0]   = 1'b1;
        if (evt_tx)  lsr_d[5]   = 1'b1;
        lsr_d[4:1] = lsr_d[4:1] | line_err;

        msr_d = msr_q;
        if (rd_msr) msr_d[3:0] = '0;
        if (wr_msr) msr_d      = bus_wdata;
        msr_d[3:0] = msr_d[3:0] | modem_delta;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ier_q  <= '0;
            lcr_q  <= '0;
            mcr_q  <= '0;
            lsr_q  <= '0;
            msr_q  <= '0;
            scr_q  <= '0;
            dll_q  <= '0;
            dlm_q  <= '0;
            fifo_q <= 1'b0;
        end else begin
            if (wr_ier) ier_q  <= bus_wdata[N_SRC-1:0];
            if (wr_dll) dll_q  <= bus_wdata;
            if (wr_dlm) dlm_q  <= bus_wdata;
            if (wr_fcr) fifo_q <= bus_wdata[0];
            if (wr_lcr) lcr_q  <= bus_wdata;
            if (wr_mcr) mcr_q  <= bus_wdata;
            if (wr_scr) scr_q  <= bus_wdata;
            lsr_q <= lsr_d;
            msr_q <= msr_d;
        end
    end

    uirq_pending #(.N(N_SRC)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .set  (set_v),
        .clr  (clr_v),
        .pend (pend)
    );

    uirq_prio u_prio (
        .pend  (pend),
        .ena   (ier_q),
        .ident (ident)
    );

    uirq_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .any  (ident.any),
        .out2 (mcr_q[3]),
        .irq  (irq)
    );

    // read data
    always_comb begin
        case (ofs)
            OFS_DATA: bus_rdata = dlab ? dll_q : rx_data;
            OFS_IER:  bus_rdata = dlab ? dlm_q : byte_t'(ier_q);
            OFS_IID:  bus_rdata = ident_byte(ident, fifo_q);
            OFS_LCR:  bus_rdata = lcr_q;
            OFS_MCR:  bus_rdata = mcr_q;
            OFS_LSR:  bus_rdata = lsr_q;
            OFS_MSR:  bus_rdata = msr_q;
            default:  bus_rdata = scr_q;
        endcase
    end

    // R4: request needs the gate bit and an enabled pending cause one clock earlier
    p_irq_gate_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mcr_q[3]));
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(pend & ier_q)));

    // R3: only the low nibble of an enable write is kept
    p_ier_nibble_r3: assert property (@(posedge clk) disable iff (rst)
        wr_ier |=> ier_q == $past(bus_wdata[N_SRC-1:0]));

    // R5: identification read returning 0x02 retires transmitter ready
    p_tx_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ofs == OFS_IID && bus_rdata[3:0] == 4'h2 && !evt_tx && !bus_wr)
        |=> !pend[SRC_TX]);

    // R7: line status read clears error bits and cause
    p_lsr_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && line_err == '0 && !bus_wr) |=> (lsr_q[4:1] == '0 && !pend[SRC_LINE]));

    // R8: modem status read clears delta bits and cause
    p_msr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_msr && modem_delta == '0 && !bus_wr) |=> (msr_q[3:0] == '0 && !pend[SRC_MODEM]));

    // R10: divisor access leaves the enable register alone
    p_dlab_ier_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && ofs == OFS_IER && dlab) |=> $stable(ier_q));

endmodule

// File: tb/sim_uart_irq_ident.sv
`timescale 1ns/100ps
module sim_uart_irq_ident;
    import uirq_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       evt_rx = 1'b0, evt_tx = 1'b0;
    logic [3:0] line_err = '0, modem_delta = '0;
    logic [7:0] rx_data = 8'h5A;
    logic       irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .evt_rx(evt_rx), .evt_tx(evt_tx), .line_err(line_err),
        .modem_delta(modem_delta), .rx_data(rx_data), .irq(irq)
    );

    // {lsr write, msr write, ier, out2, expected iir, expected irq}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {8'h00, 8'h00, 4'hF, 1'b1, 8'h01, 1'b0},
        {8'h21, 8'h01, 4'hF, 1'b1, 8'h04, 1'b1},
        {8'h23, 8'h01, 4'hF, 1'b1, 8'h06, 1'b1},
        {8'h23, 8'h01, 4'hB, 1'b1, 8'h04, 1'b1},
        {8'h20, 8'h08, 4'hA, 1'b1, 8'h02, 1'b1},
        {8'h20, 8'h08, 4'h8, 1'b1, 8'h00, 1'b1},
        {8'h20, 8'h08, 4'h8, 1'b0, 8'h00, 1'b0},
        {8'h01, 8'h00, 4'hE, 1'b1, 8'h01, 1'b0},
        {8'h10, 8'h00, 4'h4, 1'b1, 8'h06, 1'b1},
        {8'h00, 8'hF0, 4'h8, 1'b1, 8'h01, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse(input logic rx, input logic tx, input logic [3:0] le, input logic [3:0] md);
        @(negedge clk);
        evt_rx = rx; evt_tx = tx; line_err = le; modem_delta = md;
        @(negedge clk);
        evt_rx = 1'b0; evt_tx = 1'b0; line_err = '0; modem_delta = '0;
    endtask

    initial begin
        logic [7:0] v;
        do_reset();

        // R13 reset state
        check("R13 irq", {7'd0, irq}, 8'h00);
        rd_chk("R13 iir", 3'd2, 8'h01);
        rd_chk("R13 ier", 3'd1, 8'h00);
        rd_chk("R13 lcr", 3'd3, 8'h00);
        rd_chk("R13 mcr", 3'd4, 8'h00);
        rd_chk("R13 lsr", 3'd5, 8'h00);

        // table walk: R1 R2 R4 R9
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(3'd4, VEC[i][9] ? 8'h08 : 8'h00);
            wr(3'd5, VEC[i][29:22]);
            wr(3'd6, VEC[i][21:14]);
            wr(3'd1, {4'h0, VEC[i][13:10]});
            repeat (2) @(negedge clk);
            check("R4 irq level", {7'd0, irq}, {7'd0, VEC[i][0]});
            rd_chk("R1/R2/R9 iir", 3'd2, VEC[i][8:1]);
        end

        // R3 low nibble kept
        do_reset();
        wr(3'd1, 8'hFF);
        rd_chk("R3 ier", 3'd1, 8'h0F);

        // R4 one clock of latency
        do_reset();
        wr(3'd4, 8'h08);
        wr(3'd1, 8'h01);
        @(negedge clk) evt_rx = 1'b1;
        @(negedge clk) evt_rx = 1'b0;
        check("R4 not yet", {7'd0, irq}, 8'h00);
        @(negedge clk);
        check("R4 raised", {7'd0, irq}, 8'h01);

        // R6 fifo flag
        do_reset();
        wr(3'd2, 8'h01);
        rd_chk("R6 fifo on", 3'd2, 8'hC1);
        wr(3'd2, 8'h00);
        rd_chk("R6 fifo off", 3'd2, 8'h01);

        // R5 transmitter ready retire
        do_reset();
        wr(3'd1, 8'h02);
        pulse(1'b0, 1'b1, 4'h0, 4'h0);
        rd_chk("R5 tx code", 3'd2, 8'h02);
        rd_chk("R5 retired", 3'd2, 8'h01);
        wr(3'd1, 8'h03);
        pulse(1'b1, 1'b1, 4'h0, 4'h0);
        rd_chk("R5 rx first", 3'd2, 8'h04);
        rd_chk("R5 tx kept", 3'd2, 8'h04);
        rd_chk("R12 data", 3'd0, 8'h5A);
        rd_chk("R5 tx next", 3'd2, 8'h02);
        rd_chk("R5 tx gone", 3'd2, 8'h01);

        // R12 data read retires received byte
        do_reset();
        rx_data = 8'hA5;
        wr(3'd1, 8'h01);
        pulse(1'b1, 1'b0, 4'h0, 4'h0);
        rd_chk("R12 lsr bit0", 3'd5, 8'h01);
        rd_chk("R12 data", 3'd0, 8'hA5);
        rd_chk("R12 retired", 3'd2, 8'h01);
        rd_chk("R12 lsr cleared", 3'd5, 8'h00);

        // R7 and R11 line status
        do_reset();
        wr(3'd1, 8'h04);
        pulse(1'b1, 1'b1, 4'b0101, 4'h0);
        rd_chk("R11 line code", 3'd2, 8'h06);
        rd_chk("R7 lsr first", 3'd5, 8'h2B);
        rd_chk("R7 lsr cleared", 3'd5, 8'h21);
        rd_chk("R7 retired", 3'd2, 8'h01);

        // R8 and R11 modem status
        do_reset();
        wr(3'd6, 8'h90);
        wr(3'd1, 8'h08);
        rd_chk("R9 no raise", 3'd2, 8'h01);
        pulse(1'b0, 1'b0, 4'h0, 4'b0011);
        rd_chk("R11 modem code", 3'd2, 8'h00);
        rd_chk("R8 msr first", 3'd6, 8'h93);
        rd_chk("R8 msr cleared", 3'd6, 8'h90);
        rd_chk("R8 retired", 3'd2, 8'h01);

        // R10 divisor latch
        do_reset();
        rx_data = 8'h3C;
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        rd_chk("R10 dll", 3'd0, 8'h34);
        rd_chk("R10 dlm", 3'd1, 8'h12);
        wr(3'd3, 8'h03);
        rd_chk("R10 lcr", 3'd3, 8'h03);
        rd_chk("R10 ier kept", 3'd1, 8'h00);
        rd_chk("R10 data path", 3'd0, 8'h3C);

        // R11 collision: line status read with a new error
        do_reset();
        wr(3'd1, 8'h04);
        pulse(1'b0, 1'b0, 4'b0001, 4'h0);
        @(negedge clk);
        bus_addr = 3'd5; bus_rd = 1'b1; line_err = 4'b1000;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; line_err = '0;
        check("R11 collide read", v, 8'h02);
        rd_chk("R11 line kept", 3'd2, 8'h06);
        rd_chk("R11 new bit", 3'd5, 8'h10);
        rd_chk("R11 then retired", 3'd2, 8'h01);

        // R11 collision: identification read with a new transmitter event
        do_reset();
        wr(3'd1, 8'h02);
        pulse(1'b0, 1'b1, 4'h0, 4'h0);
        @(negedge clk);
        bus_addr = 3'd2; bus_rd = 1'b1; evt_tx = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; evt_tx = 1'b0;
        check("R11 tx collide read", v, 8'h02);
        rd_chk("R11 tx kept", 3'd2, 8'h02);
        rd_chk("R11 tx retired", 3'd2, 8'h01);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule